// File: doc/BRIEF.md
# Multi-operand modulo 2^n+1 adder

This combinational block adds K operands modulo M = 2^N+1 and returns the (N+1)-bit residue. Each operand is an (N+1)-bit weighted residue in the range 0 to 2^N. Only the low N bits of each operand enter the datapath. An operand equal to 2^N has its top bit set and all its low bits clear. Such an operand is accounted for by a correction word. That word is derived from a count of the set top bits and reduced modulo M in a small translation stage. K and N are parameters, with K at least 2 and N at least 2.

The low bits pass through a carry-save reduction tree of 3:2 rows. In every row, the carry leaving bit N-1 is complemented and fed back into bit 0. Because 2^N is congruent to -1 modulo M, each such row adds exactly one to the represented value. The correction word joins at a dedicated last row. It equals (-(K+m)) mod M, where m is the number of operands whose top bit is 1.

When the correction word equals 2^N, the last row is skipped by a multiplexer. A final adder then produces the residue from the two remaining N-bit vectors. This adder uses a complemented end-around carry and flags the all-propagate case as the value 2^N.

Top module: `momod_adder`

## Requirements
- R1: For operands in 0..2^N, packed with operand i in bits [i*(N+1) +: N+1], mod_sum equals the sum of all operands modulo 2^N+1.
- R2: mod_sum never exceeds 2^N; whenever bit N of mod_sum is 1, bits N-1..0 are all 0.
- R3: Each carry-save row maps (a,b,c) to (s,cv), with s = a^b^c and cv equal to the majority carries shifted up one place. The carry out of bit N-1 is complemented into bit 0, so that s+cv is congruent to a+b+c+1 modulo 2^N+1; results are right when top-bit carries occur.
- R4: The correction word equals (-(K+m)) mod (2^N+1), where m counts the operands whose bit N is 1.
- R5: When the correction word equals 2^N, the last row is bypassed, and the result still satisfies R1.
- R6: The final adder maps two N-bit vectors a, b to (a+b+1) mod (2^N+1), producing 2^N exactly when a+b = 2^N-1.
- R7: With every operand equal to 2^N, mod_sum equals (-K) mod (2^N+1).
- R8: For N=3, K=4, operands (7,4,5,0) give 7 and (8,4,6,3) give 3; for N=2, K=6, operands (1,1,3,1,0,1) give 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_bus | input | OPND_CNT*(DIG_W+1) | Packed operands, operand i in bits [i*(DIG_W+1) +: DIG_W+1] |
| mod_sum | output | DIG_W+1 | Sum of the operands modulo 2^DIG_W+1 |

## Verification
The checks assume that every operand is a proper residue, 0 to 2^N. In particular, a set top bit always comes with clear low bits, since the correction word replaces the value 2^N by -1. The bench draws each random operand from 0..2^N, forces 2^N in about a quarter of the draws, and builds its directed vectors from in-range values only, so that range assumption is never broken. Two instances are run: N=3 with K=4, and N=2 with K=6. The second reaches the bypass case, where K+m is congruent to 1.

// File: rtl/momod_pkg.sv
package momod_pkg;

    // modulus 2^n+1
    function automatic int unsigned modulus(int unsigned n);
        return (32'd1 << n) + 32'd1;
    endfunction

    // (-(k+m)) mod (2^n+1), the value the last row must inject
    function automatic int unsigned corr_value(int unsigned k, int unsigned m, int unsigned n);
        int unsigned t;
        t = (k + m) % modulus(n);
        return (t == 0) ? 32'd0 : modulus(n) - t;
    endfunction

endpackage

// File: rtl/momod_csa_row.sv
module momod_csa_row #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] c,
    output logic [N-1:0] s,
    output logic [N-1:0] cv
);
    import momod_pkg::*;

    logic [N-1:0] maj;

    assign s   = a ^ b ^ c;
    assign maj = (a & b) | (a & c) | (b & c);
    // carry of weight 2^N re-enters at bit 0 complemented
    assign cv  = {maj[N-2:0], ~maj[N-1]};

    always_comb begin
        // R3
        row_congruence_chk: assert (((32'(a) + 32'(b) + 32'(c) + 32'd1) % modulus(N))
                                    == ((32'(s) + 32'(cv)) % modulus(N)))
            else $error("carry-save row lost congruence");
    end
endmodule

// File: rtl/momod_corr_gen.sv
module momod_corr_gen #(
    parameter int K = 4,
    parameter int N = 3
) (
    input  logic [K-1:0] msb_vec,
    output logic [N:0]   corr
);
    import momod_pkg::*;

    localparam int CW = $clog2(K + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < K; i++) begin
            ones = ones + CW'(msb_vec[i]);
        end
    end

    assign corr = (N+1)'(corr_value(32'(K), 32'(ones), 32'(N)));

    always_comb begin
        // R4
        corr_cancel_chk: assert (((32'(corr) + 32'(K) + 32'(ones)) % modulus(N)) == 32'd0)
            else $error("correction does not cancel bias");
        // R4
        corr_range_chk: assert (32'(corr) <= (32'd1 << N))
            else $error("correction out of range");
    end
endmodule

// File: rtl/momod_final_add.sv
module momod_final_add #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N:0]   res
);
    import momod_pkg::*;

    logic [N-1:0] gen, prop, cy, sum_lo;
    logic         grp_g, grp_p, cr;

    always_comb begin
        gen   = a & b;
        prop  = a ^ b;
        grp_g = 1'b0;
        grp_p = 1'b1;
        for (int i = 0; i < N; i++) begin
            grp_g = gen[i] | (prop[i] & grp_g);
            grp_p = grp_p & prop[i];
        end
        // complemented end-around carry
        cr = ~grp_g;
        for (int i = 0; i < N; i++) begin
            cy[i] = cr;
            cr    = gen[i] | (prop[i] & cr);
        end
        sum_lo = prop ^ cy;
    end

    assign res = {grp_p, sum_lo};

    always_comb begin
        // R2
        fin_zero_low_chk: assert (!res[N] || (res[N-1:0] == '0))
            else $error("top bit set with nonzero low bits");
        // R6
        fin_biased_sum_chk: assert (32'(res) == ((32'(a) + 32'(b) + 32'd1) % modulus(N)))
            else $error("final adder wrong");
    end
endmodule

// File: rtl/momod_adder.sv
module momod_adder #(
    parameter int OPND_CNT = 4,
    parameter int DIG_W    = 3
) (
    input  logic [OPND_CNT*(DIG_W+1)-1:0] opnd_bus,
    output logic [DIG_W:0]                mod_sum
);
    import momod_pkg::*;

    localparam int OW       = DIG_W + 1;
    localparam int ROWS     = OPND_CNT - 2;
    localparam int POOL_LEN = 3 * OPND_CNT - 4;
    localparam int TAIL0    = 3 * OPND_CNT - 6;

    typedef struct packed {
        logic [DIG_W-1:0] sv;
        logic [DIG_W-1:0] cv;
    } cs_pair_t;

    logic [DIG_W-1:0] pool [POOL_LEN];
    logic [OPND_CNT-1:0] msb_vec;
    logic [DIG_W:0]      corr;
    cs_pair_t            tree_out, last_out, fin_in;

    for (genvar i = 0; i < OPND_CNT; i++) begin : g_split
        assign pool[i]    = opnd_bus[i*OW +: DIG_W];
        assign msb_vec[i] = opnd_bus[i*OW + DIG_W];
    end

    // queue-ordered tree: row j eats entries 3j..3j+2, appends two
    for (genvar j = 0; j < ROWS; j++) begin : g_row
        momod_csa_row #(.N(DIG_W)) u_row (
            .a (pool[3*j]),
            .b (pool[3*j+1]),
            .c (pool[3*j+2]),
            .s (pool[OPND_CNT+2*j]),
            .cv(pool[OPND_CNT+2*j+1])
        );
    end

    assign tree_out.sv = pool[TAIL0];
    assign tree_out.cv = pool[TAIL0+1];

    momod_corr_gen #(.K(OPND_CNT), .N(DIG_W)) u_corr (
        .msb_vec(msb_vec),
        .corr   (corr)
    );

    momod_csa_row #(.N(DIG_W)) u_last (
        .a (tree_out.sv),
        .b (tree_out.cv),
        .c (corr[DIG_W-1:0]),
        .s (last_out.sv),
        .cv(last_out.cv)
    );

    // correction of 2^N is -1: skip the last row entirely
    assign fin_in = corr[DIG_W] ? tree_out : last_out;

    momod_final_add #(.N(DIG_W)) u_fin (
        .a  (fin_in.sv),
        .b  (fin_in.cv),
        .res(mod_sum)
    );

    always_comb begin
        longint unsigned tot;
        tot = 0;
        for (int i = 0; i < OPND_CNT; i++) begin
            // R1
            opnd_range_chk: assert (32'(opnd_bus[i*OW +: OW]) <= (32'd1 << DIG_W))
                else $error("operand out of range");
            tot = tot + 64'(opnd_bus[i*OW +: OW]);
        end
        // R1
        mod_sum_chk: assert (64'(mod_sum) == (tot % 64'(modulus(DIG_W))))
            else $error("modular sum wrong");
    end
endmodule

// File: tb/test_momod_adder.sv
`timescale 1ns/1ps
module test_momod_adder;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic [15:0] bus_a;
    logic [3:0]  res_a;
    logic [17:0] bus_b;
    logic [2:0]  res_b;

    momod_adder #(.OPND_CNT(4), .DIG_W(3)) i_momod_adder (
        .opnd_bus(bus_a), .mod_sum(res_a));
    momod_adder #(.OPND_CNT(6), .DIG_W(2)) i_momod_adder_b (
        .opnd_bus(bus_b), .mod_sum(res_b));

    int errs = 0;
    int checks = 0;

    // {op3, op2, op1, op0, expected}; N=3, K=4, modulus 9
    localparam logic [19:0] VEC [10] = '{
        {4'd0, 4'd5, 4'd4, 4'd7, 4'd7},
        {4'd3, 4'd6, 4'd4, 4'd8, 4'd3},
        {4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
        {4'd8, 4'd8, 4'd8, 4'd8, 4'd5},
        {4'd0, 4'd0, 4'd0, 4'd8, 4'd8},
        {4'd7, 4'd7, 4'd7, 4'd7, 4'd1},
        {4'd0, 4'd0, 4'd1, 4'd8, 4'd0},
        {4'd0, 4'd0, 4'd4, 4'd4, 4'd8},
        {4'd0, 4'd0, 4'd8, 4'd8, 4'd7},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mod(input logic [63:0] bus, input int k, input int n);
        longint s;
        s = 0;
        for (int i = 0; i < k; i++) s = s + longint'((bus >> (i*(n+1))) & ((64'd1 << (n+1)) - 1));
        return int'(s % ((64'd1 << n) + 1));
    endfunction

    task automatic drive(input logic [15:0] va, input logic [17:0] vb);
        @(negedge clk);
        bus_a = va;
        bus_b = vb;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] ra;
        logic [17:0] rb;
        rst = 1'b1;
        bus_a = '0;
        bus_b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        chk("R1 idle a", int'(res_a), 0);
        chk("R1 idle b", int'(res_b), 0);

        // table: R1, R3 (top-bit carries), R4, R6, R7, R8
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][19:4], '0);
            chk($sformatf("R1 table %0d", i), int'(res_a), int'(VEC[i][3:0]));
        end

        drive({4'd0, 4'd5, 4'd4, 4'd7}, '0);
        chk("R8 ex 7,4,5,0", int'(res_a), 7);
        drive({4'd3, 4'd6, 4'd4, 4'd8}, '0);
        chk("R8 ex 8,4,6,3", int'(res_a), 3);
        drive({4'd8, 4'd8, 4'd8, 4'd8}, '0);
        chk("R7 all 2^N a", int'(res_a), 5);
        drive({4'd0, 4'd0, 4'd0, 4'd8}, '0);
        chk("R2 msb", int'(res_a[3]), 1);
        chk("R2 low zero", int'(res_a[2:0]), 0);
        drive({4'd0, 4'd0, 4'd1, 4'd7}, '0);
        chk("R6 all-propagate", int'(res_a), 8);
        drive({4'd7, 4'd7, 4'd7, 4'd7}, '0);
        chk("R3 top carries", int'(res_a), 1);
        drive({4'd0, 4'd8, 4'd8, 4'd8}, '0);
        chk("R4 three msbs", int'(res_a), 6);

        drive('0, {3'd1, 3'd0, 3'd1, 3'd3, 3'd1, 3'd1});
        chk("R8 ex six operands", int'(res_b), 2);
        chk("R5 bypass m=0", int'(res_b), 2);
        drive('0, {3'd3, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4});
        chk("R5 bypass m=5", int'(res_b), 3);
        drive('0, {3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4});
        chk("R7 all 2^N b", int'(res_b), 4);
        chk("R2 msb b", int'(res_b[2]), 1);
        drive('0, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4});
        chk("R4 one msb b", int'(res_b), 4);

        for (int t = 0; t < 3000; t++) begin
            for (int i = 0; i < 4; i++)
                ra[i*4 +: 4] = ($urandom % 4 == 0) ? 4'd8 : 4'($urandom_range(0, 8));
            for (int i = 0; i < 6; i++)
                rb[i*3 +: 3] = ($urandom % 4 == 0) ? 3'd4 : 3'($urandom_range(0, 4));
            drive(ra, rb);
            chk("R1 random a", int'(res_a), ref_mod(64'(ra), 4, 3));
            chk("R1 random b", int'(res_b), ref_mod(64'(rb), 6, 2));
            chk("R2 range a", int'(res_a <= 4'd8), 1);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule